// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block models a synchronous SRAM whose words are made of byte lanes (two 9-bit lanes by default). Every input is registered on the rising clock. Reads are flow-through: the word at the address registered on an edge appears on the output in the cycle that follows that same edge, with no second register. For a write, the address is registered on one edge and the data is taken on the next enabled edge. Because of this one-clock lag, reads and writes can follow one another in any order at full rate with no idle cycles.

An active-low clock enable freezes the whole block, including a write whose data is still owed and the burst position. An advance/load input either loads a new address and operation or steps through a four-word burst in linear or interleaved order. Three chip enables select the device. An asynchronous active-low output enable gates the drive indication. The shared bidirectional data bus is split into `din`, `dout` and `dout_en`, where `dout_en` high means the block would drive the bus. The data pins follow the fixed timing of the memory protocol. They carry no valid/ready handshake and offer no back-pressure: a transfer is owed on every enabled edge that the protocol names.

Top module: `zbt_ft_sram`

## Requirements
- R1: When a cycle with `cen_n`=0 and `adv_ld`=0 has the device selected and `we_n`=1, the stored word at `addr` appears on `dout` with `dout_en`=1 (if `oe_n`=0) in the cycle right after that edge.
- R2: When a loaded cycle has the device selected and `we_n`=0, the data on `din` at the next enabled edge is written to that address. A `bw_n[i]`=0 (captured with the address) writes lane i (`din[9i+8:9i]`). Lanes with `bw_n[i]`=1 keep their old value.
- R3: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 on a load edge. Any other combination is a deselect: `dout_en`=0 in the next cycle and nothing is written. After reset the block is deselected with `dout_en`=0.
- R4: In the cycle after a write is registered (its data phase), `dout_en` is 0.
- R5: `dout_en` is 0 whenever `oe_n`=1, at once and with no clock edge needed. When `oe_n` returns to 0 during a read, the drive comes back at once.
- R6: An edge with `cen_n`=1 is ignored. Outputs, the burst position and any owed write data all hold. The write data is then taken on the next edge with `cen_n`=0.
- R7: Read-after-write to the same address returns the new data in the very next cycle. A write may directly follow a read with no idle cycle.
- R8: With `burst_ilv`=0 at load, each edge with `adv_ld`=1 moves the two low address bits to (start + n) mod 4 and keeps the loaded operation type. During an advance, `addr`, the chip enables and `we_n` are ignored.
- R9: With `burst_ilv`=1 at load, advance edges give the low bits start XOR n, where n counts 0,1,2,3 and then wraps to 0.
- R10: A deselect cycle that directly follows a write still takes that write's data from `din` and stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of control state (not of the array) |
| cen_n | input | 1 | Active-low clock enable; high suspends the edge |
| addr | input | ADDR_W | Word address, sampled on load edges |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| we_n | input | 1 | Active-low write enable, sampled on load edges |
| bw_n | input | NUM_BYTES | Active-low byte lane selects |
| adv_ld | input | 1 | 1 = advance burst, 0 = load new address and operation |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | BYTE_W*NUM_BYTES | Write data, taken one enabled edge after its address |
| dout | output | BYTE_W*NUM_BYTES | Read data (zero when not driving) |
| dout_en | output | 1 | High when the block drives the data bus |

## Verification
A wrong burst counter or burst-order choice makes the second word of a burst come from the wrong address. The bench sees this in the first advanced cycle, because every test address holds a distinct value. A lost or late owed write shows up as stale data in the very next read of that address. A frozen-state bug under suspend shows up as `dout` changing across a suspended edge. A bad select or data-phase decode makes `dout_en` rise in a cycle where the bus belongs to the writer, and this is visible in that same cycle.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;
  localparam int BURST_W = 2;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_e;

  // low address bits for burst step n from start position
  function automatic logic [BURST_W-1:0] burst_lo(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] step,
    input burst_order_e       order
  );
    if (order == ORDER_XOR) return start ^ step;
    return start + step;
  endfunction
endpackage

// File: rtl/zbt_cmd_reg.sv
`timescale 1ns/1ps
module zbt_cmd_reg
  import zbt_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cen_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 ce1_n,
  input  logic                 ce2,
  input  logic                 ce3_n,
  input  logic                 we_n,
  input  logic [NUM_BYTES-1:0] bw_n,
  input  logic                 adv_ld,
  input  logic                 burst_ilv,
  output logic                 op_valid,
  output logic                 op_write,
  output logic [ADDR_W-1:0]    op_addr,
  output logic [NUM_BYTES-1:0] op_lane_n
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic               selected;
  logic [HI_W-1:0]    base_hi;
  logic [BURST_W-1:0] start_lo;
  logic [BURST_W-1:0] step_cnt;
  burst_order_e       order_q;

  assign selected = !ce1_n && ce2 && !ce3_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid  <= 1'b0;
      op_write  <= 1'b0;
      base_hi   <= '0;
      start_lo  <= '0;
      step_cnt  <= '0;
      order_q   <= ORDER_LINEAR;
      op_lane_n <= '1;
    end else if (!cen_n) begin
      op_lane_n <= bw_n;
      if (!adv_ld) begin
        op_valid <= selected;
        op_write <= !we_n;
        base_hi  <= addr[ADDR_W-1:BURST_W];
        start_lo <= addr[BURST_W-1:0];
        step_cnt <= '0;
        order_q  <= burst_ilv ? ORDER_XOR : ORDER_LINEAR;
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  assign op_addr = {base_hi, burst_lo(start_lo, step_cnt, order_q)};
endmodule

// File: rtl/zbt_lane_store.sv
`timescale 1ns/1ps
module zbt_lane_store #(
  parameter int ADDR_W    = 6,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2
) (
  input  logic                        clk,
  input  logic                        cen_n,
  input  logic                        wr_en,
  input  logic [NUM_BYTES-1:0]        wr_lane_n,
  input  logic [ADDR_W-1:0]           word_addr,
  input  logic [BYTE_W*NUM_BYTES-1:0] wr_data,
  output logic [BYTE_W*NUM_BYTES-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  // word_addr is the old operation's address at the edge (write side)
  // and the newly registered one after it (flow-through read side)
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (!cen_n && wr_en && !wr_lane_n[g])
        lane_mem[word_addr] <= wr_data[g*BYTE_W +: BYTE_W];
    end

    assign rd_data[g*BYTE_W +: BYTE_W] = lane_mem[word_addr];
  end
endmodule

// File: rtl/zbt_out_drv.sv
`timescale 1ns/1ps
module zbt_out_drv #(
  parameter int DATA_W = 18
) (
  input  logic              op_valid,
  input  logic              op_write,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  // drive only for a selected read; a write's data phase stays off the bus
  assign dout_en = op_valid && !op_write && !oe_n;
  assign dout    = dout_en ? rd_data : '0;
endmodule

// File: rtl/zbt_ft_sram.sv
`timescale 1ns/1ps
module zbt_ft_sram #(
  parameter int ADDR_W    = 6,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cen_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        ce1_n,
  input  logic                        ce2,
  input  logic                        ce3_n,
  input  logic                        we_n,
  input  logic [NUM_BYTES-1:0]        bw_n,
  input  logic                        adv_ld,
  input  logic                        burst_ilv,
  input  logic                        oe_n,
  input  logic [BYTE_W*NUM_BYTES-1:0] din,
  output logic [BYTE_W*NUM_BYTES-1:0] dout,
  output logic                        dout_en
);
  localparam int DATA_W = BYTE_W * NUM_BYTES;

  logic                 op_valid;
  logic                 op_write;
  logic [ADDR_W-1:0]    op_addr;
  logic [NUM_BYTES-1:0] op_lane_n;
  logic [DATA_W-1:0]    rd_data;

  zbt_cmd_reg #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .addr(addr),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .bw_n(bw_n),
    .adv_ld(adv_ld), .burst_ilv(burst_ilv),
    .op_valid(op_valid), .op_write(op_write), .op_addr(op_addr),
    .op_lane_n(op_lane_n)
  );

  zbt_lane_store #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_store (
    .clk(clk), .cen_n(cen_n), .wr_en(op_valid && op_write),
    .wr_lane_n(op_lane_n), .word_addr(op_addr), .wr_data(din),
    .rd_data(rd_data)
  );

  zbt_out_drv #(.DATA_W(DATA_W)) u_drv (
    .op_valid(op_valid), .op_write(op_write), .oe_n(oe_n),
    .rd_data(rd_data), .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: rtl/zbt_ft_sram_chk.sv
`timescale 1ns/1ps
module zbt_ft_sram_chk #(
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cen_n,
  input logic                        ce1_n,
  input logic                        ce2,
  input logic                        ce3_n,
  input logic                        we_n,
  input logic                        adv_ld,
  input logic                        oe_n,
  input logic [BYTE_W*NUM_BYTES-1:0] dout,
  input logic                        dout_en
);
  logic sel_in;
  assign sel_in = !ce1_n && ce2 && !ce3_n;

  // R5
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  // R4
  write_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cen_n && !adv_ld && sel_in && !we_n) |-> !dout_en);

  // R3
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cen_n && !adv_ld && !sel_in) |-> !dout_en);

  // R1
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cen_n && !adv_ld && sel_in && we_n) && !oe_n) |-> dout_en);

  // R6
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cen_n) && $stable(oe_n)) |-> ($stable(dout) && $stable(dout_en)));
endmodule

bind zbt_ft_sram zbt_ft_sram_chk #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
  .ce3_n(ce3_n), .we_n(we_n), .adv_ld(adv_ld), .oe_n(oe_n),
  .dout(dout), .dout_en(dout_en)
);

// File: tb/zbt_ft_sram_bench.sv
`timescale 1ns/1ps
module zbt_ft_sram_bench;
  localparam int AW = 6;
  localparam int DW = 18;
  localparam logic [2:0] SEL = 3'b010;   // {ce1_n, ce2, ce3_n}

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0, cen_n = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic          we_n = 1'b1, adv_ld = 1'b0, burst_ilv = 1'b0, oe_n = 1'b0;
  logic [1:0]    bw_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  zbt_ft_sram u_zbt_ft_sram (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .addr(addr), .ce1_n(ce1_n),
    .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .bw_n(bw_n), .adv_ld(adv_ld),
    .burst_ilv(burst_ilv), .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  typedef struct {
    int            due;
    bit            chk;
    bit            drv;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc++;

  // monitor: compares the cycle after each registered edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        bit   want_en;
        e = q.pop_front();
        want_en = e.drv && !oe_n;
        if (e.chk) begin
          n_chk++;
          if (dout_en !== want_en || (want_en && dout !== e.d)) begin
            n_fail++;
            $display("FAIL %s: dout_en=%0b dout=%05h expected dout_en=%0b dout=%05h",
                     e.tag, dout_en, dout, want_en, e.d);
          end
        end
      end
    end
  end

  task automatic direct(input string tag, input bit got_en, input bit exp_en,
                        input logic [DW-1:0] got_d, input logic [DW-1:0] exp_d);
    n_chk++;
    if (got_en !== exp_en || (exp_en && got_d !== exp_d)) begin
      n_fail++;
      $display("FAIL %s: dout_en=%0b dout=%05h expected dout_en=%0b dout=%05h",
               tag, got_en, got_d, exp_en, exp_d);
    end
  endtask

  // driver: applies one cycle of inputs and queues what should follow the edge
  task automatic step(input bit cen, input logic [2:0] ce, input bit we,
                      input logic [1:0] bwn, input bit adv, input bit ilv,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input bit o,
                      input bit chk, input bit drv, input logic [DW-1:0] exp,
                      input string tag);
    exp_t e;
    @(negedge clk);
    cen_n = cen; {ce1_n, ce2, ce3_n} = ce; we_n = we; bw_n = bwn;
    adv_ld = adv; burst_ilv = ilv; addr = a; din = d; oe_n = o;
    e.due = cyc + 1; e.chk = chk; e.drv = drv; e.d = exp; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic [DW-1:0] exp, input string tag);
    step(1'b0, SEL, 1'b1, 2'b11, 1'b0, 1'b0, a, d, 1'b0, 1'b1, 1'b1, exp, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] bwn,
                    input logic [DW-1:0] d, input string tag);
    step(1'b0, SEL, 1'b0, bwn, 1'b0, 1'b0, a, d, 1'b0, 1'b1, 1'b0, '0, tag);
  endtask

  task automatic adv(input bit we, input logic [DW-1:0] d, input bit drv,
                     input logic [DW-1:0] exp, input string tag);
    step(1'b0, 3'b101, we, 2'b00, 1'b1, 1'b0, 6'h3F, d, 1'b0, 1'b1, drv, exp, tag);
  endtask

  task automatic idle(input logic [DW-1:0] d, input string tag);
    step(1'b0, 3'b110, 1'b1, 2'b11, 1'b0, 1'b0, '0, d, 1'b0, 1'b1, 1'b0, '0, tag);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [DW-1:0] wv(input logic [AW-1:0] a);
    return 18'h15500 | DW'(a);
  endfunction

  initial begin
    #(200000 * 5.0);
    n_chk++;
    n_fail++;
    $display("FAIL R1: watchdog expired actual=running expected=finished");
    finish_up();
  end

  localparam logic [DW-1:0] D1 = 18'h2A5C3, D2 = 18'h13579, D3 = 18'h0F0F1;
  localparam logic [DW-1:0] D4 = 18'h3E11E, D5 = 18'h1B2D4, D6 = 18'h24681;
  localparam logic [DW-1:0] D7 = 18'h30C3A, D8 = 18'h05A5B;

  initial begin
    repeat (4) @(negedge clk);
    direct("R3 reset", dout_en, 1'b0, dout, '0);
    rst_n = 1'b1;
    idle('0, "R3");

    // R7 back-to-back write/read mix, R4 data phase quiet, R1 plain read
    wr(6'd5, 2'b00, '0, "R4");
    rd(6'd5, D1, D1, "R7");
    wr(6'd6, 2'b00, '0, "R4");
    wr(6'd7, 2'b00, D2, "R4");
    rd(6'd6, D3, D2, "R7");
    rd(6'd7, '0, D3, "R1");

    // R2 byte lanes: bw_n[0] -> din[8:0], bw_n[1] -> din[17:9]
    wr(6'd5, 2'b10, '0, "R2");
    rd(6'd5, D4, {D1[17:9], D4[8:0]}, "R2");
    wr(6'd5, 2'b01, '0, "R2");
    rd(6'd5, D5, {D5[17:9], D4[8:0]}, "R2");

    // R3 select decode
    wr(6'd8, 2'b00, '0, "R4");
    rd(6'd8, D6, D6, "R1");
    for (int c = 0; c < 8; c++) begin
      if (3'(c) != SEL) begin
        step(1'b0, 3'(c), 1'b0, 2'b00, 1'b0, 1'b0, 6'd8, '0, 1'b0, 1'b1, 1'b0, '0, "R3");
        rd(6'd8, 18'h3FFFF, D6, "R3");
        step(1'b0, 3'(c), 1'b1, 2'b11, 1'b0, 1'b0, 6'd8, '0, 1'b0, 1'b1, 1'b0, '0, "R3");
      end
    end

    // R5 output enable high blocks drive of a read
    rd(6'd8, '0, D6, "R5");
    step(1'b0, 3'b110, 1'b1, 2'b11, 1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 1'b0, '0, "R5");
    idle('0, "R5");

    // R6 suspend: owed write data waits for the next enabled edge
    wr(6'd9, 2'b00, '0, "R4");
    step(1'b1, SEL, 1'b0, 2'b00, 1'b0, 1'b0, 6'd8, 18'h3FFFF, 1'b0, 1'b1, 1'b0, '0, "R6");
    step(1'b1, SEL, 1'b1, 2'b00, 1'b0, 1'b0, 6'd8, 18'h2AAAA, 1'b0, 1'b1, 1'b0, '0, "R6");
    rd(6'd9, D7, D7, "R6");
    step(1'b1, SEL, 1'b0, 2'b00, 1'b0, 1'b0, 6'd8, 18'h11111, 1'b0, 1'b1, 1'b1, D7, "R6");
    step(1'b1, 3'b101, 1'b0, 2'b00, 1'b1, 1'b0, 6'd2, 18'h22222, 1'b0, 1'b1, 1'b1, D7, "R6");
    rd(6'd9, '0, D7, "R6");

    // R10 deselect right after a write still stores the data
    wr(6'd10, 2'b00, '0, "R4");
    idle(D8, "R10");
    rd(6'd10, '0, D8, "R10");

    // R8 linear write burst from low bits 2: 2,3,0,1
    wr(6'h12, 2'b00, '0, "R8");
    adv(1'b1, wv(6'h12), 1'b0, '0, "R8");
    adv(1'b1, wv(6'h13), 1'b0, '0, "R8");
    adv(1'b1, wv(6'h10), 1'b0, '0, "R8");
    rd(6'h10, wv(6'h11), wv(6'h10), "R8");
    adv(1'b0, '0, 1'b1, wv(6'h11), "R8");
    adv(1'b0, '0, 1'b1, wv(6'h12), "R8");
    adv(1'b0, '0, 1'b1, wv(6'h13), "R8");
    adv(1'b0, '0, 1'b1, wv(6'h10), "R8");

    // R9 interleaved read from low bits 1: 1,0,3,2 then wrap
    step(1'b0, SEL, 1'b1, 2'b11, 1'b0, 1'b1, 6'h11, '0, 1'b0, 1'b1, 1'b1, wv(6'h11), "R9");
    adv(1'b0, '0, 1'b1, wv(6'h10), "R9");
    adv(1'b0, '0, 1'b1, wv(6'h13), "R9");
    adv(1'b0, '0, 1'b1, wv(6'h12), "R9");
    adv(1'b0, '0, 1'b1, wv(6'h11), "R9");

    // R5 asynchronous effect while the clock edge is suspended
    rd(6'd8, '0, D6, "R1");
    step(1'b1, SEL, 1'b1, 2'b11, 1'b0, 1'b0, 6'd8, '0, 1'b0, 1'b1, 1'b1, D6, "R6");
    #1.2;
    oe_n = 1'b1;
    #0.4;
    direct("R5 async off", dout_en, 1'b0, dout, '0);
    oe_n = 1'b0;
    #0.4;
    direct("R5 async on", dout_en, 1'b1, dout, D6);

    idle('0, "R3");
    idle('0, "R3");
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule